// File: doc/BRIEF.md
# Configurable Bidirectional Pin Cell

This block sits between one pad slice and the core logic. A 3-bit mode field turns it into one of five pin types. It can be a plain input, where the pad value goes straight through. It can be an input captured by a flip-flop on the rising edge of the I/O clock line. It can be an input held by a level-sensitive latch. It can be an output that always drives. It can be a bidirectional pin whose driver is switched by an enable shared across a group of cells.

On the outbound side, the core value goes to the pad either unchanged or inverted, under control of a polarity bit. In every mode, the core-facing input is fed from one of three sources: the pad bypass, the capture register or the latch. In output mode the pad value can still be read back.

An active-low reset clears the capture register and the latch at once, without waiting for a clock edge. The pad data is WIDTH bits wide. All bits share the same mode, polarity and enable.

Top module: `pio_cell`

## Requirements
- R1: When mode_cfg is 3'b000 (plain input) or 3'b100 (bidirectional), core_in equals pad_i in the same cycle, with no clock involved.
- R2: When mode_cfg is 3'b001 (registered input), core_in shows the pad_i value sampled at the most recent rising edge of io_clk.
- R3: When mode_cfg is 3'b010 (latched input), core_in follows pad_i while io_clk is high. While io_clk is low, core_in keeps the value pad_i had when io_clk fell.
- R4: In every mode, pad_o equals core_out when inv_out is 0, and equals the bitwise inverse of core_out when inv_out is 1.
- R5: pad_oe is 0 for mode_cfg values 3'b000, 3'b001, 3'b010, 3'b101, 3'b110 and 3'b111. It is 1 for 3'b011 (output). It equals grp_oe for 3'b100 (bidirectional).
- R6: When mode_cfg is 3'b011 (output), core_in equals pad_i, so the driven pad level can be read back.
- R7: While rst_n is 0, the capture register and the latch are held at zero regardless of io_clk. core_in therefore reads all zeros in modes 3'b001 and 3'b010.
- R8: mode_cfg values 3'b101, 3'b110 and 3'b111 behave exactly like 3'b000: core_in follows pad_i and pad_oe is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| io_clk | input | 1 | I/O clock line: rising edge loads the register, high level opens the latch |
| rst_n | input | 1 | Active-low asynchronous clear of register and latch |
| mode_cfg | input | 3 | Pin type selection |
| inv_out | input | 1 | 1 inverts the outbound data |
| grp_oe | input | 1 | Output enable shared by a group of cells, used in bidirectional mode |
| core_out | input | WIDTH | Data from core logic toward the pad |
| pad_i | input | WIDTH | Level observed on the pad |
| pad_o | output | WIDTH | Data driven to the pad |
| pad_oe | output | 1 | Pad driver enable (1 = drive, 0 = high impedance) |
| core_in | output | WIDTH | Data presented to core logic |

## Verification
The hardest case to reach is the latch holding a value while the pad changes underneath it. This only shows up when pad_i moves during the low phase of io_clk, and an edge-aligned stimulus never produces it. The bench therefore drives two pad values per clock period, one just after the rising edge and one just after the falling edge, and compares the outputs in each half. The capture register, the open latch and the closed latch thus all see values that differ from one another.

A second reset is applied in the middle of the run while io_clk is high. This checks that the clear overrides a latch that is transparent at that moment.

// File: rtl/pio_cell_pkg.sv
package pio_cell_pkg;

    typedef enum logic [2:0] {
        PM_COMB  = 3'd0,
        PM_REG   = 3'd1,
        PM_LATCH = 3'd2,
        PM_OUT   = 3'd3,
        PM_BIDIR = 3'd4
    } pin_mode_e;

    // decoded steering controls
    typedef struct packed {
        logic use_reg;
        logic use_lat;
        logic drv_always;
        logic drv_group;
    } mode_ctl_t;

endpackage

// File: rtl/pio_mode_dec.sv
module pio_mode_dec
    import pio_cell_pkg::*;
(
    input  logic [2:0] mode_cfg,
    output mode_ctl_t  ctl
);

    mode_ctl_t ctl_d;

    always_comb begin
        ctl_d = '0;
        case (mode_cfg)
            PM_REG:   ctl_d.use_reg    = 1'b1;
            PM_LATCH: ctl_d.use_lat    = 1'b1;
            PM_OUT:   ctl_d.drv_always = 1'b1;
            PM_BIDIR: ctl_d.drv_group  = 1'b1;
            default:  ctl_d = '0; // plain input, also spare codes
        endcase
    end

    assign ctl = ctl_d;

endmodule

// File: rtl/pio_capture.sv
module pio_capture #(
    parameter int WIDTH = 1
) (
    input  logic             io_clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pad_i,
    output logic [WIDTH-1:0] reg_val,
    output logic [WIDTH-1:0] lat_val
);

    typedef struct packed {
        logic [WIDTH-1:0] smp;
    } cap_t;

    cap_t cap_d, cap_q;
    logic [WIDTH-1:0] lat_q;

    always_comb begin
        cap_d     = cap_q;
        cap_d.smp = pad_i;
    end

    always_ff @(posedge io_clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else begin
            cap_q <= cap_d;
        end
    end

    // level-sensitive hold: open while io_clk is high
    always_latch begin
        if (!rst_n) begin
            lat_q <= '0;
        end else if (io_clk) begin
            lat_q <= pad_i;
        end
    end

    assign reg_val = cap_q.smp;
    assign lat_val = lat_q;

endmodule

// File: rtl/pio_drive.sv
module pio_drive
    import pio_cell_pkg::*;
#(
    parameter int WIDTH = 1
) (
    input  mode_ctl_t        ctl,
    input  logic             inv_out,
    input  logic             grp_oe,
    input  logic [WIDTH-1:0] core_out,
    output logic [WIDTH-1:0] pad_o,
    output logic             pad_oe
);

    typedef struct packed {
        logic [WIDTH-1:0] dat;
        logic             en;
    } drv_t;

    drv_t drv_d;

    always_comb begin
        drv_d.dat = core_out ^ {WIDTH{inv_out}};
        drv_d.en  = ctl.drv_always | (ctl.drv_group & grp_oe);
    end

    assign pad_o  = drv_d.dat;
    assign pad_oe = drv_d.en;

endmodule

// File: rtl/pio_cell.sv
module pio_cell
    import pio_cell_pkg::*;
#(
    parameter int WIDTH = 1
) (
    input  logic             io_clk,
    input  logic             rst_n,
    input  logic [2:0]       mode_cfg,
    input  logic             inv_out,
    input  logic             grp_oe,
    input  logic [WIDTH-1:0] core_out,
    input  logic [WIDTH-1:0] pad_i,
    output logic [WIDTH-1:0] pad_o,
    output logic             pad_oe,
    output logic [WIDTH-1:0] core_in
);

    mode_ctl_t        ctl;
    logic [WIDTH-1:0] reg_val;
    logic [WIDTH-1:0] lat_val;
    logic [WIDTH-1:0] in_d;

    pio_mode_dec u_dec (
        .mode_cfg (mode_cfg),
        .ctl      (ctl)
    );

    pio_capture #(.WIDTH(WIDTH)) u_cap (
        .io_clk  (io_clk),
        .rst_n   (rst_n),
        .pad_i   (pad_i),
        .reg_val (reg_val),
        .lat_val (lat_val)
    );

    pio_drive #(.WIDTH(WIDTH)) u_drv (
        .ctl      (ctl),
        .inv_out  (inv_out),
        .grp_oe   (grp_oe),
        .core_out (core_out),
        .pad_o    (pad_o),
        .pad_oe   (pad_oe)
    );

    // inbound source selection; bypass otherwise (incl. readback)
    always_comb begin
        if (ctl.use_reg) begin
            in_d = reg_val;
        end else if (ctl.use_lat) begin
            in_d = lat_val;
        end else begin
            in_d = pad_i;
        end
    end

    assign core_in = in_d;

endmodule

// File: rtl/pio_cell_chk.sv
module pio_cell_chk #(
    parameter int WIDTH = 1
) (
    input logic             io_clk,
    input logic             rst_n,
    input logic [2:0]       mode_cfg,
    input logic             inv_out,
    input logic             grp_oe,
    input logic [WIDTH-1:0] core_out,
    input logic [WIDTH-1:0] pad_i,
    input logic [WIDTH-1:0] pad_o,
    input logic             pad_oe,
    input logic [WIDTH-1:0] core_in
);

    logic past_ok_q;

    always_ff @(posedge io_clk or negedge rst_n) begin
        if (!rst_n) begin
            past_ok_q <= 1'b0;
        end else begin
            past_ok_q <= 1'b1;
        end
    end

    // R2
    reg_capture_chk: assert property (@(posedge io_clk) disable iff (!rst_n)
        (past_ok_q && mode_cfg == 3'd1 && $past(mode_cfg) == 3'd1) |-> core_in == $past(pad_i));

    // R4
    polarity_chk: assert property (@(posedge io_clk) disable iff (!rst_n)
        pad_o == (core_out ^ {WIDTH{inv_out}}));

    // R5
    oe_input_chk: assert property (@(posedge io_clk) disable iff (!rst_n)
        (mode_cfg != 3'd3 && mode_cfg != 3'd4) |-> !pad_oe);

    // R5
    oe_output_chk: assert property (@(posedge io_clk) disable iff (!rst_n)
        (mode_cfg == 3'd3) |-> pad_oe);

    // R5
    oe_group_chk: assert property (@(posedge io_clk) disable iff (!rst_n)
        (mode_cfg == 3'd4) |-> pad_oe == grp_oe);

    // R6
    readback_chk: assert property (@(posedge io_clk) disable iff (!rst_n)
        (mode_cfg == 3'd3) |-> core_in == pad_i);

    // R8
    spare_code_chk: assert property (@(posedge io_clk) disable iff (!rst_n)
        (mode_cfg > 3'd4) |-> (core_in == pad_i && !pad_oe));

endmodule

bind pio_cell pio_cell_chk #(.WIDTH(WIDTH)) u_chk (
    .io_clk   (io_clk),
    .rst_n    (rst_n),
    .mode_cfg (mode_cfg),
    .inv_out  (inv_out),
    .grp_oe   (grp_oe),
    .core_out (core_out),
    .pad_i    (pad_i),
    .pad_o    (pad_o),
    .pad_oe   (pad_oe),
    .core_in  (core_in)
);

// File: tb/pio_cell_test.sv
`timescale 1ns/1ps
module pio_cell_test;

    localparam int W = 4;

    logic         io_clk = 1'b0;
    logic         rst_n;
    logic [2:0]   mode_cfg;
    logic         inv_out;
    logic         grp_oe;
    logic [W-1:0] core_out;
    logic [W-1:0] pad_i;
    logic [W-1:0] pad_o;
    logic         pad_oe;
    logic [W-1:0] core_in;

    int checks = 0;
    int fails  = 0;
    logic [W-1:0] reg_m = '0;
    logic [W-1:0] lat_m = '0;
    bit done = 0;

    always #4 io_clk = ~io_clk;

    pio_cell #(.WIDTH(W)) uut (
        .io_clk(io_clk), .rst_n(rst_n), .mode_cfg(mode_cfg), .inv_out(inv_out),
        .grp_oe(grp_oe), .core_out(core_out), .pad_i(pad_i), .pad_o(pad_o),
        .pad_oe(pad_oe), .core_in(core_in)
    );

    task automatic chk(input string req, input string what, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        logic [W-1:0] exp_in;
        logic         exp_oe;
        string        rq;
        case (mode_cfg)
            3'd1:    begin exp_in = reg_m; rq = "R2"; end
            3'd2:    begin exp_in = lat_m; rq = "R3"; end
            3'd3:    begin exp_in = pad_i; rq = "R6"; end
            3'd0, 3'd4: begin exp_in = pad_i; rq = "R1"; end
            default: begin exp_in = pad_i; rq = "R8"; end
        endcase
        exp_oe = (mode_cfg == 3'd3) ? 1'b1 : (mode_cfg == 3'd4) ? grp_oe : 1'b0;
        chk(rq, "core_in", core_in, exp_in);
        chk("R4", "pad_o", pad_o, core_out ^ {W{inv_out}});
        chk((mode_cfg > 3'd4) ? "R8" : "R5", "pad_oe", {{(W-1){1'b0}}, pad_oe},
            {{(W-1){1'b0}}, exp_oe});
    endtask

    // one period: new pad value in high phase, another in low phase
    task automatic run_cycle(input logic [2:0] m, input logic inv, input logic goe,
                             input logic [W-1:0] cout, input logic [W-1:0] pa,
                             input logic [W-1:0] pb);
        @(posedge io_clk);
        reg_m = pad_i;
        #1;
        mode_cfg = m; inv_out = inv; grp_oe = goe; core_out = cout; pad_i = pa;
        #2;
        lat_m = pa;
        compare_all();
        @(negedge io_clk);
        #1;
        pad_i = pb;
        #2;
        compare_all();
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; mode_cfg = 3'd1; inv_out = 1'b0; grp_oe = 1'b0;
        core_out = 4'h0; pad_i = 4'hA;
        #5;  // io_clk high: register saw an edge, latch would be open
        chk("R7", "core_in reg mode in reset", core_in, 4'h0);
        mode_cfg = 3'd2;
        #1;
        chk("R7", "core_in latch mode in reset", core_in, 4'h0);
        @(negedge io_clk); #1;
        rst_n = 1'b1;
        reg_m = '0; lat_m = '0;

        for (int m = 0; m < 8; m++) begin
            for (int k = 0; k < 4; k++) begin
                run_cycle(3'(m), k[0], k[1], 4'((m * 5 + k * 3) ^ 4'h6),
                          4'((m * 7 + k * 11 + 1)), 4'((m * 3 + k * 13 + 9)));
            end
        end

        // bidir with both enable values and both polarities
        run_cycle(3'd4, 1'b1, 1'b1, 4'hC, 4'h3, 4'hE);
        run_cycle(3'd4, 1'b0, 1'b0, 4'h5, 4'h8, 4'h1);
        // latch hold then register, back to back
        run_cycle(3'd2, 1'b0, 1'b0, 4'h0, 4'hF, 4'h0);
        run_cycle(3'd1, 1'b1, 1'b0, 4'hF, 4'h7, 4'h2);
        run_cycle(3'd1, 1'b0, 1'b0, 4'h9, 4'h4, 4'hB);

        // reset while latch is open (io_clk high)
        @(posedge io_clk); #1;
        mode_cfg = 3'd2; pad_i = 4'hD;
        #1;
        rst_n = 1'b0;
        #1;
        chk("R7", "latch cleared while open", core_in, 4'h0);
        mode_cfg = 3'd1;
        #0.5;
        chk("R7", "register cleared", core_in, 4'h0);
        @(negedge io_clk); #1;
        rst_n = 1'b1;
        reg_m = '0; lat_m = '0;
        mode_cfg = 3'd2; pad_i = 4'h6;
        #1;
        chk("R3", "closed latch after reset", core_in, 4'h0);
        run_cycle(3'd2, 1'b0, 1'b0, 4'h1, 4'h2, 4'h3);
        run_cycle(3'd1, 1'b0, 1'b0, 4'h1, 4'h5, 4'hA);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule